// File: doc/BRIEF.md
# Secure-Module Locality Claim Sequencer

This block brings a register-mapped security module out of reset. After a one-cycle `start` pulse it walks a fixed chain of register transactions: it identifies the device, checks that the access register shows a clean reset state, and asks for locality zero. Every transaction is issued on a request port that carries an address, a byte count and write data. A separate transport layer carries the request and returns one response with a success flag and read data.

When the chain ends, the block gives a one-cycle `done` pulse. With that pulse it holds a pass or fail flag and a failure code that names the step that went wrong. On success it keeps the 16-bit vendor and device identifiers and the revision byte. It raises `cmd_enable`, the gate for a later command engine, only when the vendor identifier is nonzero.

Top module: `tpm_loc_init`

## Requirements
- R1: After reset `req_valid`, `done`, `fail`, `cmd_enable` are low, and `fail_code`, `vendor_id`, `device_id` and `revision` are zero.
- R2: The first transaction after `start` is a 4-byte read (`req_len`=4, `req_write`=0) at address 0xD40F00. A response with `rsp_ok`=0 on any transaction ends the run at once with `fail`=1 and `fail_code`=1, and no further request is made.
- R3: The access register (address 0xD40000) is read with `req_len`=1. If the byte read has both bit 7 and bit 5 set, the block writes 0x20 to it once and reads it again. It never releases a second time.
- R4: The last access value read before the claim must equal 0x80 with bit 0 masked off. Otherwise the run fails with `fail_code`=2.
- R5: The block then writes 0x02 to the access register and reads it back. The value with bit 0 masked must equal 0xA0, otherwise the run fails with `fail_code`=3.
- R6: The block reads 4 bytes from 0xD40018. Bits 27:26 must equal 2'b01, otherwise the run fails with `fail_code`=4.
- R7: On success the last transaction is a 1-byte read of 0xD40F04, and `done` pulses for one cycle with `fail`=0 and `fail_code`=0. The outputs then hold `vendor_id` = identifier word bits 15:0, `device_id` = bits 31:16, and `revision` = bits 7:0 of that last read.
- R8: `cmd_enable` rises with `done` only on success with a nonzero vendor identifier. It stays low on failure and clears when the next run starts.
- R9: A request holds `req_valid` and its fields steady until `req_ready` is seen. Only one transaction is outstanding at any time, and writes go only to the access register with one byte.
- R10: A `start` pulse while a run is in progress has no effect. The run makes the same transactions and gives one `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins the sequence when idle |
| req_valid | output | 1 | Transaction request pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 24 | Register address |
| req_len | output | 3 | Byte count (1 or 4) |
| req_wdata | output | 32 | Write data, low bytes used |
| req_ready | input | 1 | Transport accepts the request this cycle |
| rsp_valid | input | 1 | Transaction response present |
| rsp_ok | input | 1 | Response success flag |
| rsp_rdata | input | 32 | Read data, byte 0 in bits 7:0 |
| done | output | 1 | One-cycle end-of-sequence pulse |
| fail | output | 1 | Sequence failed (valid from `done`) |
| fail_code | output | 3 | 0 none, 1 transport, 2 reset state, 3 claim refused, 4 family |
| vendor_id | output | 16 | Captured vendor identifier |
| device_id | output | 16 | Captured device identifier |
| revision | output | 8 | Captured revision byte |
| cmd_enable | output | 1 | Permission for the later command engine |

## Verification
The checker assumes that the transport answers each accepted request with exactly one `rsp_valid` pulse. It also assumes that this pulse arrives at least one cycle after `req_ready`, and that neither signal is driven while nothing is outstanding. The bench's transport model gives `req_ready` only while `req_valid` is high. It returns the response a few cycles later and then stays quiet until the next request. Its data come from per-scenario tables, so the order of access-register values, error injection and family values is chosen by each scenario alone.

// File: rtl/tpm_init_pkg.sv
package tpm_init_pkg;

  // access register bit positions
  localparam int ACC_VALID_BIT  = 7;
  localparam int ACC_ACTIVE_BIT = 5;
  localparam int ACC_REQ_BIT    = 1;
  localparam int ACC_EST_BIT    = 0;

  // status register family field
  localparam int STS_FAM_LO  = 26;
  localparam int STS_FAM_W   = 2;
  localparam int STS_FAM_VAL = 1;

  // register offsets from the locality base
  localparam int OFS_ACCESS = 'h000;
  localparam int OFS_STATUS = 'h018;
  localparam int OFS_IDENT  = 'hF00;
  localparam int OFS_REV    = 'hF04;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_IDENT,
    ST_ACC_FIRST,
    ST_RELEASE,
    ST_ACC_AFTER,
    ST_REQUEST,
    ST_ACC_CLAIM,
    ST_STATUS,
    ST_REV
  } seq_state_e;

  typedef enum logic [2:0] {
    FC_NONE   = 3'd0,
    FC_XPORT  = 3'd1,
    FC_RESET  = 3'd2,
    FC_CLAIM  = 3'd3,
    FC_FAMILY = 3'd4
  } fail_code_e;

  typedef enum logic [1:0] {
    XP_IDLE,
    XP_REQ,
    XP_WAIT
  } xp_state_e;

endpackage

// File: rtl/tpm_xact_port.sv
module tpm_xact_port
  import tpm_init_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kick,
  input  logic              k_write,
  input  logic [ADDR_W-1:0] k_addr,
  input  logic [LEN_W-1:0]  k_len,
  input  logic [DATA_W-1:0] k_wdata,
  output logic              req_valid,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic              rsp_ok,
  input  logic [DATA_W-1:0] rsp_rdata,
  output logic              fin,
  output logic              fin_ok,
  output logic [DATA_W-1:0] fin_data
);

  xp_state_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= XP_IDLE;
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_len   <= '0;
      req_wdata <= '0;
      fin       <= 1'b0;
      fin_ok    <= 1'b0;
      fin_data  <= '0;
    end else begin
      fin <= 1'b0;
      case (st)
        XP_IDLE: begin
          if (kick) begin
            req_valid <= 1'b1;
            req_write <= k_write;
            req_addr  <= k_addr;
            req_len   <= k_len;
            req_wdata <= k_wdata;
            st        <= XP_REQ;
          end
        end
        XP_REQ: begin
          if (req_ready) begin
            req_valid <= 1'b0;
            st        <= XP_WAIT;
          end
        end
        XP_WAIT: begin
          if (rsp_valid) begin
            fin      <= 1'b1;
            fin_ok   <= rsp_ok;
            fin_data <= rsp_rdata;
            st       <= XP_IDLE;
          end
        end
        default: st <= XP_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tpm_access_judge.sv
module tpm_access_judge
  import tpm_init_pkg::*;
#(
  parameter int ACC_W = 8,
  parameter int STS_W = 32
) (
  input  logic [ACC_W-1:0] acc_val,
  input  logic [STS_W-1:0] sts_val,
  output logic             loc_active,
  output logic             reset_clean,
  output logic             claim_granted,
  output logic             family_ok
);

  localparam logic [ACC_W-1:0] VALID_M  = ACC_W'(1) << ACC_VALID_BIT;
  localparam logic [ACC_W-1:0] ACTIVE_M = ACC_W'(1) << ACC_ACTIVE_BIT;
  localparam logic [ACC_W-1:0] EST_M    = ACC_W'(1) << ACC_EST_BIT;
  localparam logic [STS_FAM_W-1:0] FAM_V = STS_FAM_W'(STS_FAM_VAL);

  logic [ACC_W-1:0] masked;

  always_comb begin
    masked        = acc_val & ~EST_M;
    loc_active    = acc_val[ACC_VALID_BIT] & acc_val[ACC_ACTIVE_BIT];
    reset_clean   = (masked == VALID_M);
    claim_granted = (masked == (VALID_M | ACTIVE_M));
    family_ok     = (sts_val[STS_FAM_LO +: STS_FAM_W] == FAM_V);
  end

endmodule

// File: rtl/tpm_id_capture.sv
module tpm_id_capture #(
  parameter int DATA_W = 32,
  parameter int ID_W   = 16,
  parameter int REV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              cap_id,
  input  logic [DATA_W-1:0] id_word,
  input  logic              grant,
  input  logic [REV_W-1:0]  rev_byte,
  output logic [ID_W-1:0]   vendor_id,
  output logic [ID_W-1:0]   device_id,
  output logic [REV_W-1:0]  revision,
  output logic              cmd_enable
);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      vendor_id  <= '0;
      device_id  <= '0;
      revision   <= '0;
      cmd_enable <= 1'b0;
    end else begin
      if (cap_id) begin
        vendor_id <= id_word[ID_W-1:0];
        device_id <= id_word[2*ID_W-1:ID_W];
      end
      if (grant) begin
        revision   <= rev_byte;
        cmd_enable <= (vendor_id != '0);
      end
    end
  end

endmodule

// File: rtl/tpm_loc_init.sv
module tpm_loc_init
  import tpm_init_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 32,
  parameter int LEN_W    = 3,
  parameter int ID_W     = 16,
  parameter int REV_W    = 8,
  parameter int LOC_BASE = 'hD40000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              req_valid,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic              rsp_ok,
  input  logic [DATA_W-1:0] rsp_rdata,
  output logic              done,
  output logic              fail,
  output logic [2:0]        fail_code,
  output logic [ID_W-1:0]   vendor_id,
  output logic [ID_W-1:0]   device_id,
  output logic [REV_W-1:0]  revision,
  output logic              cmd_enable
);

  localparam logic [ADDR_W-1:0] A_ACC = ADDR_W'(LOC_BASE + OFS_ACCESS);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(LOC_BASE + OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_ID  = ADDR_W'(LOC_BASE + OFS_IDENT);
  localparam logic [ADDR_W-1:0] A_REV = ADDR_W'(LOC_BASE + OFS_REV);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int ACC_W = 8;
  localparam logic [DATA_W-1:0] W_RELEASE = DATA_W'(1) << ACC_ACTIVE_BIT;
  localparam logic [DATA_W-1:0] W_REQUEST = DATA_W'(1) << ACC_REQ_BIT;

  seq_state_e        state;
  logic              kick;
  logic              op_write;
  logic [ADDR_W-1:0] op_addr;
  logic [LEN_W-1:0]  op_len;
  logic [DATA_W-1:0] op_wdata;
  logic              xfin, xok;
  logic [DATA_W-1:0] xdata;
  logic              loc_active, reset_clean, claim_granted, family_ok;
  logic              cap_id, grant, clear;

  // transaction parameters are a function of the current step
  always_comb begin
    op_write = 1'b0;
    op_addr  = A_ACC;
    op_len   = LEN_W'(1);
    op_wdata = '0;
    case (state)
      ST_IDENT: begin
        op_addr = A_ID;
        op_len  = LEN_W'(WORD_BYTES);
      end
      ST_RELEASE: begin
        op_write = 1'b1;
        op_wdata = W_RELEASE;
      end
      ST_REQUEST: begin
        op_write = 1'b1;
        op_wdata = W_REQUEST;
      end
      ST_STATUS: begin
        op_addr = A_STS;
        op_len  = LEN_W'(WORD_BYTES);
      end
      ST_REV: op_addr = A_REV;
      default: ;
    endcase
  end

  tpm_xact_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_port (
    .clk       (clk),
    .rst       (rst),
    .kick      (kick),
    .k_write   (op_write),
    .k_addr    (op_addr),
    .k_len     (op_len),
    .k_wdata   (op_wdata),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .req_wdata (req_wdata),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ok    (rsp_ok),
    .rsp_rdata (rsp_rdata),
    .fin       (xfin),
    .fin_ok    (xok),
    .fin_data  (xdata)
  );

  tpm_access_judge #(.ACC_W(ACC_W), .STS_W(DATA_W)) u_judge (
    .acc_val       (xdata[ACC_W-1:0]),
    .sts_val       (xdata),
    .loc_active    (loc_active),
    .reset_clean   (reset_clean),
    .claim_granted (claim_granted),
    .family_ok     (family_ok)
  );

  assign cap_id = xfin && xok && (state == ST_IDENT);
  assign grant  = xfin && xok && (state == ST_REV);
  assign clear  = start && (state == ST_IDLE);

  tpm_id_capture #(.DATA_W(DATA_W), .ID_W(ID_W), .REV_W(REV_W)) u_ids (
    .clk        (clk),
    .rst        (rst),
    .clear      (clear),
    .cap_id     (cap_id),
    .id_word    (xdata),
    .grant      (grant),
    .rev_byte   (xdata[REV_W-1:0]),
    .vendor_id  (vendor_id),
    .device_id  (device_id),
    .revision   (revision),
    .cmd_enable (cmd_enable)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      kick      <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
      fail_code <= FC_NONE;
    end else begin
      kick <= 1'b0;
      done <= 1'b0;
      if (state == ST_IDLE) begin
        if (start) begin
          state     <= ST_IDENT;
          kick      <= 1'b1;
          fail      <= 1'b0;
          fail_code <= FC_NONE;
        end
      end else if (xfin) begin
        if (!xok) begin
          state     <= ST_IDLE;
          done      <= 1'b1;
          fail      <= 1'b1;
          fail_code <= FC_XPORT;
        end else begin
          case (state)
            ST_IDENT: begin
              state <= ST_ACC_FIRST;
              kick  <= 1'b1;
            end
            ST_ACC_FIRST: begin
              if (loc_active) begin
                state <= ST_RELEASE;
                kick  <= 1'b1;
              end else if (reset_clean) begin
                state <= ST_REQUEST;
                kick  <= 1'b1;
              end else begin
                state     <= ST_IDLE;
                done      <= 1'b1;
                fail      <= 1'b1;
                fail_code <= FC_RESET;
              end
            end
            ST_RELEASE: begin
              state <= ST_ACC_AFTER;
              kick  <= 1'b1;
            end
            ST_ACC_AFTER: begin
              if (reset_clean) begin
                state <= ST_REQUEST;
                kick  <= 1'b1;
              end else begin
                state     <= ST_IDLE;
                done      <= 1'b1;
                fail      <= 1'b1;
                fail_code <= FC_RESET;
              end
            end
            ST_REQUEST: begin
              state <= ST_ACC_CLAIM;
              kick  <= 1'b1;
            end
            ST_ACC_CLAIM: begin
              if (claim_granted) begin
                state <= ST_STATUS;
                kick  <= 1'b1;
              end else begin
                state     <= ST_IDLE;
                done      <= 1'b1;
                fail      <= 1'b1;
                fail_code <= FC_CLAIM;
              end
            end
            ST_STATUS: begin
              if (family_ok) begin
                state <= ST_REV;
                kick  <= 1'b1;
              end else begin
                state     <= ST_IDLE;
                done      <= 1'b1;
                fail      <= 1'b1;
                fail_code <= FC_FAMILY;
              end
            end
            ST_REV: begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/tpm_loc_init_chk.sv
module tpm_loc_init_chk #(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 32,
  parameter int LEN_W    = 3,
  parameter int ID_W     = 16,
  parameter int LOC_BASE = 'hD40000
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [LEN_W-1:0]  req_len,
  input logic [DATA_W-1:0] req_wdata,
  input logic              done,
  input logic              fail,
  input logic [2:0]        fail_code,
  input logic [ID_W-1:0]   vendor_id,
  input logic              cmd_enable
);

  localparam logic [ADDR_W-1:0] A_ACC = ADDR_W'(LOC_BASE);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_len));

  // R3
  write_target_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_write |-> req_addr == A_ACC && req_len == LEN_W'(1)
      && (req_wdata[7:0] == 8'h20 || req_wdata[7:0] == 8'h02));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  pass_code_chk: assert property (@(posedge clk) disable iff (rst)
    done && !fail |-> fail_code == 3'd0);

  // R4
  fail_code_chk: assert property (@(posedge clk) disable iff (rst)
    done && fail |-> fail_code != 3'd0);

  // R8
  enable_vendor_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_enable |-> vendor_id != '0 && !fail);

  // R9
  idle_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !req_valid);

endmodule

bind tpm_loc_init tpm_loc_init_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .ID_W(ID_W), .LOC_BASE(LOC_BASE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .req_len    (req_len),
  .req_wdata  (req_wdata),
  .done       (done),
  .fail       (fail),
  .fail_code  (fail_code),
  .vendor_id  (vendor_id),
  .cmd_enable (cmd_enable)
);

// File: tb/tpm_loc_init_test.sv
`timescale 1ns/1ps
module tpm_loc_init_test;

  localparam logic [23:0] A_ACC = 24'hD40000;
  localparam logic [23:0] A_STS = 24'hD40018;
  localparam logic [23:0] A_ID  = 24'hD40F00;
  localparam logic [23:0] A_REV = 24'hD40F04;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        req_valid, req_write;
  logic [23:0] req_addr;
  logic [2:0]  req_len;
  logic [31:0] req_wdata;
  logic        req_ready = 1'b0;
  logic        rsp_valid = 1'b0;
  logic        rsp_ok = 1'b0;
  logic [31:0] rsp_rdata = '0;
  logic        done, fail, cmd_enable;
  logic [2:0]  fail_code;
  logic [15:0] vendor_id, device_id;
  logic [7:0]  revision;

  always #4 clk = ~clk;

  tpm_loc_init uut (
    .clk(clk), .rst(rst), .start(start),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_len(req_len), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_rdata(rsp_rdata),
    .done(done), .fail(fail), .fail_code(fail_code),
    .vendor_id(vendor_id), .device_id(device_id), .revision(revision),
    .cmd_enable(cmd_enable)
  );

  int n_chk = 0;
  int n_bad = 0;
  int done_cnt = 0;

  // transport model configuration and log
  logic [31:0] cfg_id, cfg_sts;
  logic [7:0]  cfg_acc [0:3];
  logic [7:0]  cfg_rev;
  int          cfg_err_at = -1;
  int          n_tx = 0;
  int          acc_idx = 0;
  logic [23:0] lg_addr [0:15];
  logic        lg_wr   [0:15];
  logic [2:0]  lg_len  [0:15];
  logic [7:0]  lg_wd   [0:15];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (req_valid) begin
        logic [31:0] d;
        logic        ok;
        if (n_tx < 16) begin
          lg_addr[n_tx] = req_addr;
          lg_wr[n_tx]   = req_write;
          lg_len[n_tx]  = req_len;
          lg_wd[n_tx]   = req_wdata[7:0];
        end
        ok = (n_tx != cfg_err_at);
        d  = 32'h0;
        if (!req_write) begin
          if (req_addr == A_ID) d = cfg_id;
          else if (req_addr == A_STS) d = cfg_sts;
          else if (req_addr == A_REV) d = {24'h0, cfg_rev};
          else if (req_addr == A_ACC) begin
            d = {24'h0, cfg_acc[acc_idx & 3]};
            acc_idx++;
          end
        end
        n_tx++;
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        repeat (2) @(negedge clk);
        rsp_valid = 1'b1;
        rsp_ok    = ok;
        rsp_rdata = d;
        @(negedge clk);
        rsp_valid = 1'b0;
        rsp_ok    = 1'b0;
        rsp_rdata = '0;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (done) done_cnt++;
  end

  task automatic setup(input logic [31:0] id, input logic [7:0] a0, input logic [7:0] a1,
                       input logic [7:0] a2, input logic [31:0] sts, input logic [7:0] rv,
                       input int err_at);
    cfg_id = id; cfg_acc[0] = a0; cfg_acc[1] = a1; cfg_acc[2] = a2; cfg_acc[3] = 8'h00;
    cfg_sts = sts; cfg_rev = rv; cfg_err_at = err_at; n_tx = 0; acc_idx = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int t = 0;
    while (!done && t < 3000) begin
      @(negedge clk);
      t++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL %s actual=no_done expected=done", tag);
    end
  endtask

  task automatic chk_tx(input string tag, input int i, input logic wr, input logic [23:0] a,
                        input logic [2:0] len, input logic [7:0] wd);
    chk({tag, " addr"}, {8'h0, lg_addr[i]}, {8'h0, a});
    chk({tag, " dir"}, {31'h0, lg_wr[i]}, {31'h0, wr});
    chk({tag, " len"}, {29'h0, lg_len[i]}, {29'h0, len});
    if (wr) chk({tag, " wdata"}, {24'h0, lg_wd[i]}, {24'h0, wd});
  endtask

  task automatic chk_end(input string tag, input logic f, input logic [2:0] code, input int ntx);
    chk({tag, " fail"}, {31'h0, fail}, {31'h0, f});
    chk({tag, " code"}, {29'h0, fail_code}, {29'h0, code});
    chk({tag, " tx count"}, n_tx, ntx);
  endtask

  task automatic t_reset();
    chk("R1 req_valid", {31'h0, req_valid}, 0);
    chk("R1 done", {31'h0, done}, 0);
    chk("R1 fail", {31'h0, fail}, 0);
    chk("R1 code", {29'h0, fail_code}, 0);
    chk("R1 enable", {31'h0, cmd_enable}, 0);
    chk("R1 ids", {vendor_id, device_id}, 0);
    chk("R1 rev", {24'h0, revision}, 0);
  endtask

  task automatic t_clean();
    setup(32'hC0DE_15D1, 8'h81, 8'hA1, 8'h00, 32'h0400_4490, 8'h16, -1);
    pulse_start(); wait_done("R7 clean");
    chk_end("R7 clean", 1'b0, 3'd0, 6);
    chk("R7 vendor", {16'h0, vendor_id}, 32'h15D1);
    chk("R7 device", {16'h0, device_id}, 32'hC0DE);
    chk("R7 rev", {24'h0, revision}, 32'h16);
    chk("R8 enable", {31'h0, cmd_enable}, 1);
    chk_tx("R2 first", 0, 1'b0, A_ID, 3'd4, 8'h0);
    chk_tx("R3 acc read", 1, 1'b0, A_ACC, 3'd1, 8'h0);
    chk_tx("R5 request", 2, 1'b1, A_ACC, 3'd1, 8'h02);
    chk_tx("R5 reread", 3, 1'b0, A_ACC, 3'd1, 8'h0);
    chk_tx("R6 status", 4, 1'b0, A_STS, 3'd4, 8'h0);
    chk_tx("R7 rid", 5, 1'b0, A_REV, 3'd1, 8'h0);
    pulse_start();
    chk("R8 cleared on start", {31'h0, cmd_enable}, 0);
    wait_done("R8 rerun");
  endtask

  task automatic t_release();
    setup(32'h0001_1AE0, 8'hA0, 8'h80, 8'hA0, 32'h0400_0000, 8'h02, -1);
    pulse_start(); wait_done("R3 release");
    chk_end("R3 release", 1'b0, 3'd0, 8);
    chk_tx("R3 release write", 2, 1'b1, A_ACC, 3'd1, 8'h20);
    chk_tx("R3 after release", 3, 1'b0, A_ACC, 3'd1, 8'h0);
    chk_tx("R5 request", 4, 1'b1, A_ACC, 3'd1, 8'h02);
  endtask

  task automatic t_stuck();
    setup(32'h0001_1AE0, 8'hA0, 8'hA1, 8'h00, 32'h0400_0000, 8'h02, -1);
    pulse_start(); wait_done("R4 stuck");
    chk_end("R4 stuck active", 1'b1, 3'd2, 4);
    chk("R8 enable fail", {31'h0, cmd_enable}, 0);
  endtask

  task automatic t_badreset();
    setup(32'h0001_1AE0, 8'h01, 8'h00, 8'h00, 32'h0400_0000, 8'h02, -1);
    pulse_start(); wait_done("R4 bad");
    chk_end("R4 invalid", 1'b1, 3'd2, 2);
  endtask

  task automatic t_refused();
    setup(32'h0001_1AE0, 8'h80, 8'h81, 8'h00, 32'h0400_0000, 8'h02, -1);
    pulse_start(); wait_done("R5 refused");
    chk_end("R5 refused", 1'b1, 3'd3, 4);
  endtask

  task automatic t_family();
    setup(32'h0001_1AE0, 8'h80, 8'hA0, 8'h00, 32'h0800_0000, 8'h02, -1);
    pulse_start(); wait_done("R6 family");
    chk_end("R6 family", 1'b1, 3'd4, 5);
    chk("R8 enable family", {31'h0, cmd_enable}, 0);
  endtask

  task automatic t_xport();
    setup(32'h0001_1AE0, 8'h80, 8'hA0, 8'h00, 32'h0400_0000, 8'h02, 0);
    pulse_start(); wait_done("R2 err first");
    chk_end("R2 err first", 1'b1, 3'd1, 1);
    setup(32'h0001_1AE0, 8'h80, 8'hA0, 8'h00, 32'h0400_0000, 8'h02, 4);
    pulse_start(); wait_done("R2 err status");
    repeat (20) @(negedge clk);
    chk_end("R2 err status", 1'b1, 3'd1, 5);
  endtask

  task automatic t_zero_vendor();
    setup(32'h1234_0000, 8'h80, 8'hA0, 8'h00, 32'h0400_0000, 8'h5A, -1);
    pulse_start(); wait_done("R8 zero vendor");
    chk_end("R8 zero vendor", 1'b0, 3'd0, 6);
    chk("R8 zero vendor enable", {31'h0, cmd_enable}, 0);
    chk("R7 device", {16'h0, device_id}, 32'h1234);
  endtask

  task automatic t_busy_start();
    int d0;
    setup(32'h0001_1AE0, 8'h80, 8'hA0, 8'h00, 32'h0400_0000, 8'h02, -1);
    d0 = done_cnt;
    pulse_start();
    repeat (3) @(negedge clk);
    pulse_start();
    wait_done("R10 busy");
    repeat (30) @(negedge clk);
    chk("R10 tx count", n_tx, 6);
    chk("R10 done pulses", done_cnt - d0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_clean();
    t_release();
    t_stuck();
    t_badreset();
    t_refused();
    t_family();
    t_xport();
    t_zero_vendor();
    t_busy_start();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule